// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls one bidirectional port of parameterizable width, eight pins by default. A small register bus holds three pieces of state: the output latch, the direction mask and one pull-up control bit. The block drives three vectors towards the pads: the output value, the output enable and the pull-up enable. A pin whose direction bit is set is an input, so its driver is off. A pin whose direction bit is clear drives the latched value.

The latch and the pin levels are read at separate addresses. Reading the latch gives back what software wrote, whatever the pads carry, so a read-modify-write on the latch never picks up pin noise. Reading the port gives the pad inputs after a synchronizer chain. Writing to either address loads the latch. One active-low control bit turns on the weak pull-ups of every input pin. A pin that is set as an output always has its pull-up removed.

Register map, with 2-bit word addresses: 0 is the port (read gives synchronized pins, write loads the latch); 1 is the latch; 2 is the direction mask; 3 is the pull-up control, whose bit 0 is the active-low enable.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction register reads all ones, the latch reads zero, the pull-up control reads 1, pin_oe is all zeros and pin_pu is all zeros.
- R2: For each pin i, pin_oe[i] is 1 exactly when direction bit i is 0, and pin_out[i] equals latch bit i.
- R3: A read of address 1 returns the latch contents, independent of the levels on pin_in.
- R4: A write to address 0 loads bus_wdata into the output latch.
- R5: A write to address 1 loads bus_wdata into the output latch.
- R6: A read of address 0 returns pin_in as it was two rising clock edges earlier, through a two-flop synchronizer.
- R7: When pull-up control bit 0 is 0, pin_pu[i] is 1 for every pin whose direction bit is 1.
- R8: pin_pu[i] is 0 whenever direction bit i is 0, whatever the pull-up control bit holds.
- R9: A write takes effect on the rising edge where bus_we is sampled high. While bus_we is low, no register changes.
- R10: The pull-up control register stores only bit 0. Its other read bits are always zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from registered state |
| pin_in | input | 8 | Raw pad input levels |
| pin_out | output | 8 | Output value driven to pads |
| pin_oe | output | 8 | Output enable per pad |
| pin_pu | output | 8 | Weak pull-up enable per pad |

## Verification
The bench drives pin_in to the inverse of the latch and then reads both addresses. A design that returns pad levels from the latch address fails this check. The bench writes zero through the port address and separately through the latch address, so a design that ignores writes to the port address is caught. The bench also steps pin_in and reads the port one and two cycles later. A synchronizer that is too short or too long shows the new value on the wrong cycle. The bench clears the pull-up control while pins are mixed inputs and outputs, and it writes ones to the upper control bits. These checks expose a pull-up that is not gated by direction, an enable with the wrong polarity, or control bits that are stored when they should not be.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_PINS   = 2'd0,
      RA_LATCH  = 2'd1,
      RA_DIR    = 2'd2,
      RA_PUCTRL = 2'd3
   } reg_addr_e;

   function automatic logic is_latch_write(input logic [REG_ADDR_W-1:0] a);
      return (a == RA_PINS) || (a == RA_LATCH);
   endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   localparam int unsigned AGE_W = $clog2(STAGES + 1) + 1;

   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be 2..4");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign dout = chain_q[STAGES-1];

   // cycles since reset, saturating, for the latency check
   logic [AGE_W-1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   age_q <= '0;
      else if (age_q < AGE_W'(STAGES)) age_q <= age_q + 1'b1;
   end

   AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == AGE_W'(STAGES)) |-> (dout == $past(din, STAGES))); // R6
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]      wdata,
   output logic [WIDTH-1:0]      dir_q,
   output logic [WIDTH-1:0]      lat_q,
   output logic                  pu_n_q
);
   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("gpio_regfile: WIDTH must be 1..32");
   end

   logic lat_we, dir_we, pu_we;

   always_comb begin
      lat_we = we && is_latch_write(addr);
      dir_we = we && (addr == RA_DIR);
      pu_we  = we && (addr == RA_PUCTRL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_q <= '0;
      else if (lat_we) lat_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '1;
      else if (dir_we) dir_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pu_n_q <= 1'b1;
      else if (pu_we) pu_n_q <= wdata[0];
   end

   AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (addr == RA_PINS || addr == RA_LATCH)) |=> (lat_q == $past(wdata))); // R4
   AST_LATCH_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == RA_LATCH) |=> (lat_q == $past(wdata))); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(lat_q) && $stable(dir_q) && $stable(pu_n_q))); // R9
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
   parameter int unsigned WIDTH         = 8,
   parameter bit          ZERO_IDLE_OUT = 1'b0
) (
   input  logic [WIDTH-1:0] dir,
   input  logic [WIDTH-1:0] lat,
   input  logic             pu_n,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pu
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign pad_oe[i] = ~dir[i];
      assign pad_pu[i] = ~pu_n & dir[i];
      if (ZERO_IDLE_OUT) begin : g_gated
         assign pad_out[i] = lat[i] & ~dir[i];
      end else begin : g_plain
         assign pad_out[i] = lat[i];
      end
   end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic                  bus_we,
   input  logic [WIDTH-1:0]      bus_wdata,
   output logic [WIDTH-1:0]      bus_rdata,
   input  logic [WIDTH-1:0]      pin_in,
   output logic [WIDTH-1:0]      pin_out,
   output logic [WIDTH-1:0]      pin_oe,
   output logic [WIDTH-1:0]      pin_pu
);
   logic [WIDTH-1:0] dir_q, lat_q, pins_sync;
   logic             pu_n_q;

   gpio_regfile #(.WIDTH(WIDTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .dir_q(dir_q), .lat_q(lat_q), .pu_n_q(pu_n_q)
   );

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pins_sync)
   );

   gpio_pad_ctrl #(.WIDTH(WIDTH), .ZERO_IDLE_OUT(1'b0)) u_pads (
      .dir(dir_q), .lat(lat_q), .pu_n(pu_n_q),
      .pad_out(pin_out), .pad_oe(pin_oe), .pad_pu(pin_pu)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         RA_PINS:   bus_rdata = pins_sync;
         RA_LATCH:  bus_rdata = lat_q;
         RA_DIR:    bus_rdata = dir_q;
         RA_PUCTRL: bus_rdata[0] = pu_n_q;
         default:   bus_rdata = '0;
      endcase
   end

   AST_PU_NOT_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pu & pin_oe) == '0); // R8
   AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == RA_PUCTRL) |-> (bus_rdata[WIDTH-1:1] == '0)); // R10
   AST_PU_FOLLOWS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      pu_n_q |-> (pin_pu == '0)); // R7
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata, pin_in, pin_out, pin_oe, pin_pu;

   int checks = 0;
   int errors = 0;

   logic [7:0] m_dir, m_lat;
   logic       m_pun;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
   );

   function automatic logic [7:0] exp_oe(input logic [7:0] d);
      return ~d;
   endfunction

   function automatic logic [7:0] exp_pu(input logic pun, input logic [7:0] d);
      return pun ? 8'h00 : d;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      if (a == 2'd0 || a == 2'd1) m_lat = d;
      else if (a == 2'd2) m_dir = d;
      else m_pun = d[0];
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
      bus_addr = a; bus_we = 1'b0;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic pads_chk(input string req);
      chk({req, " oe"}, pin_oe, exp_oe(m_dir));
      chk({req, " out"}, pin_out, m_lat);
      chk({req, " pu"}, pin_pu, exp_pu(m_pun, m_dir));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      pin_in = 8'h00;
      m_dir = 8'hFF; m_lat = 8'h00; m_pun = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_chk("R1 dir", 2'd2, 8'hFF);
      rd_chk("R1 latch", 2'd1, 8'h00);
      rd_chk("R1 puctrl", 2'd3, 8'h01);
      chk("R1 oe", pin_oe, 8'h00);
      chk("R1 pu", pin_pu, 8'h00);

      // R5 write latch address; R2 pads
      wr(2'd1, 8'hA5);
      rd_chk("R5 latch", 2'd1, 8'hA5);
      wr(2'd2, 8'h0F);
      pads_chk("R2");

      // R3 latch read independent of pins
      pin_in = ~m_lat;
      repeat (3) @(negedge clk);
      rd_chk("R3 latch vs pins", 2'd1, 8'hA5);
      rd_chk("R6 port level", 2'd0, 8'h5A);

      // R4 clear through the port address
      wr(2'd0, 8'h00);
      rd_chk("R4 latch via port", 2'd1, 8'h00);
      wr(2'd0, 8'h3C);
      rd_chk("R4 latch via port", 2'd1, 8'h3C);
      wr(2'd1, 8'h00);
      rd_chk("R5 clear via latch", 2'd1, 8'h00);

      // R6 synchronizer latency
      @(negedge clk);
      pin_in = 8'hC3;
      @(negedge clk);
      rd_chk("R6 after one edge", 2'd0, 8'h5A);
      @(negedge clk);
      rd_chk("R6 after two edges", 2'd0, 8'hC3);

      // R7/R8 pull-ups with mixed direction
      wr(2'd2, 8'hCF);
      wr(2'd3, 8'h00);
      chk("R7 pu on inputs", pin_pu, 8'hCF);
      chk("R8 pu off on outputs", pin_pu & ~m_dir, 8'h00);
      wr(2'd2, 8'h00);
      chk("R8 all outputs", pin_pu, 8'h00);
      wr(2'd2, 8'hFF);
      chk("R7 all inputs", pin_pu, 8'hFF);

      // R10 upper control bits not stored
      wr(2'd3, 8'hFE);
      rd_chk("R10 upper ignored", 2'd3, 8'h00);
      chk("R10 pu still on", pin_pu, 8'hFF);
      wr(2'd3, 8'hFF);
      rd_chk("R10 upper zero", 2'd3, 8'h01);

      // R9 no write when bus_we low
      @(negedge clk);
      bus_addr = 2'd1; bus_wdata = 8'h77; bus_we = 1'b0;
      @(negedge clk);
      rd_chk("R9 idle latch", 2'd1, m_lat);
      // R9 write visible right after its edge
      bus_addr = 2'd2; bus_wdata = 8'h12; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0; m_dir = 8'h12;
      chk("R9 dir next edge", bus_rdata, 8'h12);

      // random mix
      for (int k = 0; k < 150; k++) begin
         logic [1:0] a;
         logic [7:0] d;
         a = 2'($urandom % 4);
         d = 8'($urandom);
         wr(a, d);
         pads_chk("R2 R7 R8 random");
         rd_chk("R3 random", 2'd1, m_lat);
         rd_chk("R10 random", 2'd3, {7'd0, m_pun});
         if (k % 10 == 0) begin
            pin_in = 8'($urandom);
            repeat (2) @(negedge clk);
            rd_chk("R6 random", 2'd0, pin_in);
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule